// File: doc/BRIEF.md
# Fixed-Priority Interrupt Acceptor

This block decides which of twelve interrupt sources a small controller core takes next. Six sources arrive as external pins that are active on a falling edge. Each pin goes through a two-stage synchronizer and an edge detector. The other six sources arrive as one-cycle request pulses from on-chip timers and serial units. Every source has a latched request flag and an enable flag, and software can write both. A single global enable flip-flop gates all acceptance. It is set and cleared by two command strobes that stand for the enable and disable instructions.

While the global enable is on, a grant ripples down a chain from the highest-priority source to the lowest. The first source whose request and enable flags are both set keeps the grant. That source's request flag is cleared, a one-cycle accept strobe is raised, and its vector address is presented. The global enable drops in the same cycle, so the core must issue the enable command again before another interrupt is taken.

Top module: `prio_irq_acceptor`

## Requirements
- R1: While reset is high and in the first cycle after it is released, all request flags, all enable flags, the global enable and the accept strobe are 0.
- R2: Source indices 0 to 5 are pins, where index 0 is the chip-enable pin and indices 1 to 5 are INT0 to INT4. A high-to-low change on a pin sets its request flag, and the flag reads 1 three clock edges after the pin is driven low. A low-to-high change sets nothing.
- R3: Sources 6 to 11 are Timer 0 to 3 followed by serial units 0 and 1. A one-cycle high on a source's bit of `periph_req_i` sets its request flag at the next edge.
- R4: A pulse on `gie_set_i` makes `gie_o` read 1 after the next edge. A pulse on `gie_clr_i` makes it read 0. When both pulses come in the same cycle, the clear wins.
- R5: A source is accepted only when `gie_o`, its request flag and its enable flag are all 1 in the same cycle. `accept_o` is then high for exactly the following cycle, and it is never high in two consecutive cycles.
- R6: When several sources qualify, the one with the lowest index is accepted.
- R7: `vec_o` equals `VEC_BASE + 4*index` of the accepted source. With the defaults this is 0x100 plus 4 times the index, as a 12-bit value. It holds its value while no strobe is raised.
- R8: Acceptance clears only the winner's request flag, and it clears the global enable in the same edge.
- R9: A source whose enable flag is 0 is never accepted, and its request flag stays 1. The next qualifying lower-priority source is accepted in its place.
- R10: If a source's set condition arrives in the cycle in which it is accepted, its request flag reads 1 afterwards.
- R11: When `wr_en_i` is high and `wr_sel_i` is 0, the request flags are loaded from `wr_data_i`, so a 0 removes a pending request. When `wr_sel_i` is 1, the enable flags are loaded instead. Both flag sets can be read back at every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_n_i | input | 6 | Asynchronous pin levels for sources 0 to 5, which request on a falling edge |
| periph_req_i | input | 6 | Request pulses for sources 6 to 11 |
| gie_set_i | input | 1 | Enable-command strobe |
| gie_clr_i | input | 1 | Disable-command strobe |
| wr_en_i | input | 1 | Flag write strobe |
| wr_sel_i | input | 1 | Write target: 0 selects the request flags, 1 selects the enable flags |
| wr_data_i | input | 12 | Flag write data, one bit per source |
| req_flags_o | output | 12 | Request flags |
| en_flags_o | output | 12 | Enable flags |
| gie_o | output | 1 | Global interrupt enable |
| accept_o | output | 1 | One-cycle accept strobe |
| vec_o | output | 12 | Vector address of the last accepted source |

## Verification
Each source is raised on its own through its real path: a pin falling edge or a peripheral pulse. This confirms the latch latency, the vector arithmetic, and that a rising edge does nothing. Every one of the 66 pairs of simultaneous requests is run, which separates a correct priority order from any permutation and checks that the loser stays pending. Sweeps that disable one source against a full request set, and that disable all sources, separate masking from priority. Directed cycles then collide a set with an accept clear and an enable command with a disable command.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic {
    SEL_REQ = 1'b0,
    SEL_EN  = 1'b1
  } flag_sel_e;
endpackage

// File: rtl/prio_irq_pin_edge.sv
module prio_irq_pin_edge #(
  parameter int NUM_PINS = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_n_i,
  output logic [NUM_PINS-1:0] fall_o
);
  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_pin
      logic meta_q, sync_q, prev_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          meta_q <= 1'b1;
          sync_q <= 1'b1;
          prev_q <= 1'b1;
        end else begin
          meta_q <= pin_n_i[g];
          sync_q <= meta_q;
          prev_q <= sync_q;
        end
      end
      assign fall_o[g] = prev_q & ~sync_q;
    end
  endgenerate
endmodule

// File: rtl/prio_irq_chain.sv
module prio_irq_chain #(
  parameter int NUM_SRC = 12,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               grant_in,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic [NUM_SRC-1:0] take_o,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [NUM_SRC:0] pass;
  assign pass[0] = grant_in;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_link
      logic want;
      assign want      = req_i[g] & en_i[g];
      assign take_o[g] = pass[g] & want;
      assign pass[g+1] = pass[g] & ~want;
    end
  endgenerate

  assign any_o = |take_o;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (take_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/prio_irq_flags.sv
module prio_irq_flags
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] take_i,
  input  logic               take_any_i,
  input  logic               gie_set_i,
  input  logic               gie_clr_i,
  input  logic               wr_en_i,
  input  flag_sel_e          wr_sel_i,
  input  logic [NUM_SRC-1:0] wr_data_i,
  output logic [NUM_SRC-1:0] req_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic               gie_o
);
  logic [NUM_SRC-1:0] req_base;

  always_comb begin
    req_base = req_o;
    if (wr_en_i && wr_sel_i == SEL_REQ) req_base = wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o <= '0;
      en_o  <= '0;
      gie_o <= 1'b0;
    end else begin
      req_o <= (req_base & ~take_i) | set_i;
      if (wr_en_i && wr_sel_i == SEL_EN) en_o <= wr_data_i;
      if (take_any_i || gie_clr_i) gie_o <= 1'b0;
      else if (gie_set_i)          gie_o <= 1'b1;
    end
  end
endmodule

// File: rtl/prio_irq_acceptor.sv
module prio_irq_acceptor
  import prio_irq_pkg::*;
#(
  parameter int          NUM_PINS   = 6,
  parameter int          NUM_PERIPH = 6,
  parameter int          VEC_W      = 12,
  parameter logic [11:0] VEC_BASE   = 12'h100,
  parameter int          STRIDE_SH  = 2,
  localparam int         NUM_SRC    = NUM_PINS + NUM_PERIPH,
  localparam int         IDX_W      = $clog2(NUM_SRC)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PINS-1:0]   pin_n_i,
  input  logic [NUM_PERIPH-1:0] periph_req_i,
  input  logic                  gie_set_i,
  input  logic                  gie_clr_i,
  input  logic                  wr_en_i,
  input  logic                  wr_sel_i,
  input  logic [NUM_SRC-1:0]    wr_data_i,
  output logic [NUM_SRC-1:0]    req_flags_o,
  output logic [NUM_SRC-1:0]    en_flags_o,
  output logic                  gie_o,
  output logic                  accept_o,
  output logic [VEC_W-1:0]      vec_o
);
  logic [NUM_PINS-1:0] pin_fall;
  logic [NUM_SRC-1:0]  set_vec, take;
  logic                take_any;
  logic [IDX_W-1:0]    take_idx;

  prio_irq_pin_edge #(.NUM_PINS(NUM_PINS)) u_edge (
    .clk(clk), .rst(rst), .pin_n_i(pin_n_i), .fall_o(pin_fall)
  );

  assign set_vec = {periph_req_i, pin_fall};

  prio_irq_chain #(.NUM_SRC(NUM_SRC)) u_chain (
    .grant_in(gie_o), .req_i(req_flags_o), .en_i(en_flags_o),
    .take_o(take), .any_o(take_any), .idx_o(take_idx)
  );

  prio_irq_flags #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_vec), .take_i(take),
    .take_any_i(take_any), .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i),
    .wr_en_i(wr_en_i), .wr_sel_i(flag_sel_e'(wr_sel_i)),
    .wr_data_i(wr_data_i), .req_o(req_flags_o), .en_o(en_flags_o),
    .gie_o(gie_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      accept_o <= 1'b0;
      vec_o    <= VEC_W'(VEC_BASE);
    end else begin
      accept_o <= take_any;
      if (take_any) vec_o <= VEC_W'(VEC_BASE) + (VEC_W'(take_idx) << STRIDE_SH);
    end
  end
endmodule

// File: rtl/prio_irq_acceptor_chk.sv
module prio_irq_acceptor_chk #(
  parameter int          NUM_SRC   = 12,
  parameter int          VEC_W     = 12,
  parameter logic [11:0] VEC_BASE  = 12'h100,
  parameter int          STRIDE_SH = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] req_flags_o,
  input logic [NUM_SRC-1:0] en_flags_o,
  input logic               gie_o,
  input logic               accept_o,
  input logic [VEC_W-1:0]   vec_o
);
  logic [NUM_SRC-1:0] q_req, q_en;
  logic               q_gie;
  int                 idx;
  logic               in_range;
  logic [NUM_SRC-1:0] low_mask, win_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_req <= '0; q_en <= '0; q_gie <= 1'b0;
    end else begin
      q_req <= req_flags_o; q_en <= en_flags_o; q_gie <= gie_o;
    end
  end

  always_comb begin
    idx      = (int'(vec_o) - int'(VEC_BASE)) >>> STRIDE_SH;
    in_range = (int'(vec_o) >= int'(VEC_BASE)) &&
               (int'(vec_o) < int'(VEC_BASE) + (NUM_SRC << STRIDE_SH)) &&
               ((int'(vec_o) - int'(VEC_BASE)) % (1 << STRIDE_SH) == 0);
    low_mask = '0;
    win_bit  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (in_range && i < idx)  low_mask[i] = 1'b1;
      if (in_range && i == idx) win_bit[i]  = 1'b1;
    end
  end

  p_accept_needs_gie_r5: assert property (@(posedge clk) disable iff (rst)
    accept_o |-> q_gie);
  p_single_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    accept_o |=> !accept_o);
  p_gie_dropped_r8: assert property (@(posedge clk) disable iff (rst)
    accept_o |-> !gie_o);
  p_vec_legal_r7: assert property (@(posedge clk) disable iff (rst)
    accept_o |-> in_range);
  p_winner_qualified_r9: assert property (@(posedge clk) disable iff (rst)
    accept_o |-> ((q_req & q_en & win_bit) == win_bit));
  p_no_higher_pending_r6: assert property (@(posedge clk) disable iff (rst)
    accept_o |-> ((q_req & q_en & low_mask) == '0));
endmodule

bind prio_irq_acceptor prio_irq_acceptor_chk #(
  .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .STRIDE_SH(STRIDE_SH)
) u_chk (
  .clk(clk), .rst(rst), .req_flags_o(req_flags_o), .en_flags_o(en_flags_o),
  .gie_o(gie_o), .accept_o(accept_o), .vec_o(vec_o)
);

// File: tb/prio_irq_acceptor_bench.sv
`timescale 1ns/1ps
module prio_irq_acceptor_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  pin_n = 6'h3F;
  logic [5:0]  preq = '0;
  logic        ei = 1'b0, di = 1'b0, wen = 1'b0, wsel = 1'b0;
  logic [11:0] wdat = '0;
  logic [11:0] req, en, vec;
  logic        gie, acc;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  prio_irq_acceptor u_prio_irq_acceptor (
    .clk(clk), .rst(rst), .pin_n_i(pin_n), .periph_req_i(preq),
    .gie_set_i(ei), .gie_clr_i(di), .wr_en_i(wen), .wr_sel_i(wsel),
    .wr_data_i(wdat), .req_flags_o(req), .en_flags_o(en), .gie_o(gie),
    .accept_o(acc), .vec_o(vec)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string rq, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic wr(bit sel, logic [11:0] d);
    wen = 1'b1; wsel = sel; wdat = d; tick(); wen = 1'b0;
  endtask

  task automatic cmd_ei();
    ei = 1'b1; tick(); ei = 1'b0;
  endtask

  function automatic int vexp(int i);
    return 'h100 + 4 * i;
  endfunction

  initial begin
    repeat (3) tick();
    chk("R1 req", int'(req), 0); chk("R1 en", int'(en), 0);
    chk("R1 gie", int'(gie), 0); chk("R1 acc", int'(acc), 0);
    rst = 1'b0; tick();
    chk("R1 req after release", int'(req), 0);
    chk("R1 acc after release", int'(acc), 0);

    wr(1, 12'hFFF);
    chk("R11 enable readback", int'(en), 'hFFF);

    // single-source sweep through real request paths
    for (int i = 0; i < 12; i++) begin
      if (i < 6) begin
        pin_n[i] = 1'b0;
        tick(); tick();
        chk("R2 latency not yet", int'(req[i]), 0);
        tick();
        chk("R2 pin fall sets", int'(req), 1 << i);
        pin_n[i] = 1'b1;
      end else begin
        preq[i-6] = 1'b1; tick(); preq[i-6] = 1'b0;
        chk("R3 pulse sets", int'(req), 1 << i);
      end
      tick();
      chk("R5 no accept without gie", int'(acc), 0);
      cmd_ei();
      chk("R4 gie set", int'(gie), 1);
      tick();
      chk("R5 accept strobe", int'(acc), 1);
      chk("R7 vector", int'(vec), vexp(i));
      chk("R8 winner cleared", int'(req), 0);
      chk("R8 gie cleared", int'(gie), 0);
      tick();
      chk("R5 strobe one cycle", int'(acc), 0);
      chk("R7 vector holds", int'(vec), vexp(i));
      tick(); tick();
      chk("R2 rising edge ignored", int'(req), 0);
    end

    // all pairs of simultaneous requests
    for (int i = 0; i < 12; i++) begin
      for (int j = i + 1; j < 12; j++) begin
        wr(0, 12'((1 << i) | (1 << j)));
        cmd_ei(); tick();
        chk("R6 higher wins", int'(vec), vexp(i));
        chk("R8 loser kept", int'(req), 1 << j);
        cmd_ei(); tick();
        chk("R6 loser next", int'(vec), vexp(j));
        chk("R8 both cleared", int'(req), 0);
      end
    end

    // masking one source at a time
    for (int i = 0; i < 12; i++) begin
      wr(1, 12'(~(1 << i)));
      wr(0, 12'hFFF);
      cmd_ei(); tick();
      chk("R9 masked skipped", int'(vec), vexp(i == 0 ? 1 : 0));
      chk("R9 masked req kept", int'(req[i]), 1);
      chk("R5 accepted", int'(acc), 1);
    end

    // all disabled: nothing taken, gie stays
    wr(1, 12'h000); wr(0, 12'hFFF);
    cmd_ei(); tick(); tick();
    chk("R9 none taken", int'(acc), 0);
    chk("R9 reqs kept", int'(req), 'hFFF);
    chk("R4 gie stays", int'(gie), 1);
    di = 1'b1; tick(); di = 1'b0;
    chk("R4 di clears", int'(gie), 0);
    ei = 1'b1; di = 1'b1; tick(); ei = 1'b0; di = 1'b0;
    chk("R4 clear wins", int'(gie), 0);

    // set collides with accept clear
    wr(1, 12'hFFF); wr(0, 12'h080);
    cmd_ei();
    preq[1] = 1'b1; tick(); preq[1] = 1'b0;
    chk("R10 accept taken", int'(acc), 1);
    chk("R10 set wins", int'(req), 'h080);

    // software clear of a pending request
    wr(0, 12'h000);
    preq[3] = 1'b1; tick(); preq[3] = 1'b0;
    chk("R3 pulse again", int'(req), 'h200);
    wr(0, 12'h000);
    chk("R11 write clears", int'(req), 0);
    cmd_ei(); tick();
    chk("R11 nothing accepted", int'(acc), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule